// File: doc/BRIEF.md
# Wait-State Memory Subordinate for an AHB-Lite Bus

This block is a bus subordinate with a small memory inside it, for a pipelined AHB-Lite bus with 32-bit addresses and data. It takes the address-phase controls on a rising clock edge where the bus ready input is high. It then finishes the data phase of that transfer. It can stretch the data phase by a fixed number of wait states, from 0 to 7, set by a static configuration input. Reads are served from a word array inside the block. Writes update that array on the edge that ends the data phase, with byte-lane selection taken from the transfer size and the low address bits.

An access inside a configurable forbidden address window does not touch storage. It skips any wait states and gets a two-cycle error response. Idle and busy transfer codes, and transfers that do not select the block, finish at once with an OKAY response. In a single-subordinate system the bus ready input is simply looped back from the block's own ready output.

Top module: `ahbw_subordinate`

## Requirements
- R1: While the reset input is low, `ready_o` is 1 and `resp_o` is 0 (OKAY).
- R2: A transfer is active when `sel_i` is 1 and `trans_i` is 2 (non-sequential) or 3 (sequential), and its address is outside the forbidden window. For such a transfer, `ready_o` stays 0 for exactly `wait_cfg_i` cycles after the capturing edge. It is then 1 for one cycle, and `resp_o` stays 0 for the whole data phase.
- R3: `trans_i` equal to 0 (idle) or 1 (busy), or `sel_i` equal to 0, gives `ready_o` = 1 and `resp_o` = 0 in the next cycle. Storage is not touched, even when `write_i` is 1.
- R4: For a read, `rdata_o` holds the stored word at index `addr[IDX_W+1:2]` during the cycle in which `ready_o` is 1.
- R5: A write stores `wdata_i` on the edge that ends its data phase. Byte lanes are little-endian (lane k is bits 8k+7:8k). Size 0 writes lane `addr[1:0]`. Size 1 writes lanes `{addr[1],0}` and `{addr[1],1}`. Size 2 writes all four lanes.
- R6: An active transfer whose address lies in [ERR_LO, ERR_HI] ignores `wait_cfg_i` and modifies no storage. In its first data-phase cycle `ready_o` is 0 and `resp_o` is 1 (ERROR); in the second, `ready_o` is 1 and `resp_o` is 1.
- R7: Address-phase inputs are captured only on an edge where `ready_i` is 1. Values driven while the current data phase is stalled have no effect.
- R8: A transfer issued in the address phase that overlaps a write's data phase sees that write. A read to the same address right after a write returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge only |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 1 | Subordinate select for the address phase |
| addr_i | input | 32 | Transfer address |
| trans_i | input | 2 | Transfer type: 0 idle, 1 busy, 2 non-sequential, 3 sequential |
| write_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 3 | Transfer size: 0 byte, 1 halfword, 2 word |
| ready_i | input | 1 | Bus ready; high marks the end of the previous data phase |
| wdata_i | input | 32 | Write data, valid in the data phase |
| wait_cfg_i | input | 3 | Static wait-state count, 0 to 7 |
| rdata_o | output | 32 | Read data, valid when `ready_o` is high on a read |
| ready_o | output | 1 | Data phase complete when high |
| resp_o | output | 1 | Response: 0 OKAY, 1 ERROR |

## Verification
Each result is due at a fixed number of cycles after the edge that captures the address phase. With N wait states, `ready_o` is low in the N cycles that follow that edge and high in cycle N+1. An error shows one low ERROR cycle and then one high ERROR cycle. Idle codes show high/OKAY in the very next cycle. The bench drives inputs and samples outputs at falling edges. It counts the low cycles it sees before the first high one, and reads `resp_o` and `rdata_o` in that high cycle, so every check lands on the cycle the requirement names. Effects on storage are checked by reading the words back through the bus.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } ahbw_trans_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DONE,
    ST_ERR1,
    ST_ERR2
  } ahbw_state_e;

  // Byte-lane strobes for a 32-bit word, little-endian lanes.
  function automatic logic [3:0] lane_strobe(logic [2:0] size, logic [1:0] off);
    logic [3:0] s;
    case (size)
      3'd0:    s = 4'b0001 << off;
      3'd1:    s = off[1] ? 4'b1100 : 4'b0011;
      default: s = 4'b1111;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ahbw_addr_stage.sv
module ahbw_addr_stage
  import ahbw_pkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter int          LOW_W  = 6,
  parameter logic [31:0] ERR_LO = 32'h0000_1000,
  parameter logic [31:0] ERR_HI = 32'h0000_1FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic              ready_i,
  output logic              start_o,
  output logic              start_err_o,
  output logic [LOW_W-1:0]  cap_lo_o,
  output logic              cap_write_o,
  output logic [2:0]        cap_size_o,
  output logic              cap_err_o
);

  logic [LOW_W-1:0] lo_q;
  logic             wr_q, err_q;
  logic [2:0]       size_q;
  logic             in_window;

  always_comb begin
    in_window   = (addr_i >= ERR_LO) && (addr_i <= ERR_HI);
    start_o     = sel_i && ((trans_i == TR_NONSEQ) || (trans_i == TR_SEQ));
    start_err_o = in_window;
  end

  // Clock enable: only an edge with the bus ready high ends the prior phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      wr_q   <= 1'b0;
      size_q <= '0;
      err_q  <= 1'b0;
    end else if (ready_i) begin
      lo_q   <= addr_i[LOW_W-1:0];
      wr_q   <= write_i && start_o;
      size_q <= size_i;
      err_q  <= in_window && start_o;
    end
  end

  assign cap_lo_o    = lo_q;
  assign cap_write_o = wr_q;
  assign cap_size_o  = size_q;
  assign cap_err_o   = err_q;

  // R7: a stalled bus leaves the captured transfer untouched.
  p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> ($stable(lo_q) && $stable(wr_q) && $stable(err_q)));

endmodule

// File: rtl/ahbw_wait_ctrl.sv
module ahbw_wait_ctrl
  import ahbw_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_i,
  input  logic             start_i,
  input  logic             start_err_i,
  input  logic [CNT_W-1:0] wait_cfg_i,
  output ahbw_state_e      state_o,
  output logic             ready_o,
  output logic             resp_o
);

  ahbw_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_WAIT: begin
        if (cnt_q == CNT_W'(1)) st_d = ST_DONE;
        cnt_d  = cnt_q - CNT_W'(1);
        cnt_en = 1'b1;
      end
      ST_ERR1: st_d = ST_ERR2;
      default: begin
        if (ready_i) begin
          if (!start_i)                st_d = ST_IDLE;
          else if (start_err_i)        st_d = ST_ERR1;
          else if (wait_cfg_i == '0)   st_d = ST_DONE;
          else begin
            st_d   = ST_WAIT;
            cnt_d  = wait_cfg_i;
            cnt_en = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign ready_o = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERR2);
  assign resp_o  = (st_q == ST_ERR1) || (st_q == ST_ERR2);

  // R1: reset holds the bus ready with OKAY.
  p_reset_ready_r1: assert property (@(posedge clk)
    !rst_n |-> (ready_o && !resp_o));

  // R3: no active transfer gives an immediate OKAY completion.
  p_idle_zero_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && !start_i) |=> (ready_o && !resp_o));

  // R2: a nonzero wait count stalls with OKAY right after capture.
  p_wait_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && start_i && !start_err_i && (wait_cfg_i != '0)) |=> (!ready_o && !resp_o));

  // R6: an error starts with a low-ready ERROR cycle, skipping waits.
  p_err_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && start_i && start_err_i) |=> (!ready_o && resp_o));

  // R6: the second error cycle raises ready and keeps ERROR.
  p_err_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && resp_o) |=> (ready_o && resp_o));

endmodule

// File: rtl/ahbw_store.sv
module ahbw_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANES-1:0]  strobe_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_q [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en_i && strobe_i[b]) lane_q[idx_i] <= wdata_i[8*b +: 8];
    end

    assign rdata_o[8*b +: 8] = lane_q[idx_i];
  end

endmodule

// File: rtl/ahbw_subordinate.sv
module ahbw_subordinate
  import ahbw_pkg::*;
#(
  parameter int          DEPTH  = 16,
  parameter int          WAIT_W = 3,
  parameter logic [31:0] ERR_LO = 32'h0000_1000,
  parameter logic [31:0] ERR_HI = 32'h0000_1FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [31:0]       addr_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic              ready_i,
  input  logic [31:0]       wdata_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  output logic [31:0]       rdata_o,
  output logic              ready_o,
  output logic              resp_o
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int LOW_W = IDX_W + 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             start, start_err;
  logic [LOW_W-1:0] cap_lo;
  logic             cap_write, cap_err;
  logic [2:0]       cap_size;
  ahbw_state_e      state;
  logic             wr_en, rd_sel;
  logic [3:0]       strobe;
  logic [31:0]      mem_rd;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ahbw_addr_stage #(
    .ADDR_W(32), .LOW_W(LOW_W), .ERR_LO(ERR_LO), .ERR_HI(ERR_HI)
  ) u_addr (
    .clk(clk), .rst_n(rst_int_n), .sel_i(sel_i), .addr_i(addr_i),
    .trans_i(trans_i), .write_i(write_i), .size_i(size_i), .ready_i(ready_i),
    .start_o(start), .start_err_o(start_err), .cap_lo_o(cap_lo),
    .cap_write_o(cap_write), .cap_size_o(cap_size), .cap_err_o(cap_err)
  );

  ahbw_wait_ctrl #(.CNT_W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_int_n), .ready_i(ready_i), .start_i(start),
    .start_err_i(start_err), .wait_cfg_i(wait_cfg_i),
    .state_o(state), .ready_o(ready_o), .resp_o(resp_o)
  );

  always_comb begin
    strobe = lane_strobe(cap_size, cap_lo[1:0]);
    wr_en  = (state == ST_DONE) && cap_write && ready_i;
    rd_sel = (state == ST_DONE) && !cap_write;
  end

  ahbw_store #(.DEPTH(DEPTH), .DATA_W(32)) u_store (
    .clk(clk), .wr_en_i(wr_en), .idx_i(cap_lo[LOW_W-1:2]),
    .strobe_i(strobe), .wdata_i(wdata_i), .rdata_o(mem_rd)
  );

  assign rdata_o = rd_sel ? mem_rd : '0;

  // R6: storage is never written for a transfer in the forbidden window.
  p_no_err_write_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |-> !cap_err);

endmodule

// File: tb/tb_ahbw_subordinate.sv
module tb_ahbw_subordinate;

  localparam logic [31:0] ERR_LO = 32'h0000_1000;
  localparam logic [31:0] ERR_HI = 32'h0000_1FFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel;
  logic [31:0] addr;
  logic [1:0]  trans;
  logic        write;
  logic [2:0]  size;
  wire logic   ready_fb;
  logic [31:0] wdata;
  logic [2:0]  wait_cfg;
  logic [31:0] rdata;
  logic        ready_out;
  logic        resp;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign ready_fb = ready_out;

  ahbw_subordinate #(.DEPTH(16), .WAIT_W(3), .ERR_LO(ERR_LO), .ERR_HI(ERR_HI)) dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .addr_i(addr), .trans_i(trans),
    .write_i(write), .size_i(size), .ready_i(ready_fb), .wdata_i(wdata),
    .wait_cfg_i(wait_cfg), .rdata_o(rdata), .ready_o(ready_out), .resp_o(resp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Runs one transfer from its address phase to the end of its data phase.
  // Returns at the falling edge where ready_out is high.
  task automatic xfer(input logic [31:0] a, input bit wr, input logic [2:0] sz,
                      input logic [31:0] wd, input bit s, input logic [1:0] tr,
                      input bit decoy, output int lows, output bit low_err,
                      output bit fin_resp, output logic [31:0] rd);
    sel = s; addr = a; trans = tr; write = wr; size = sz;
    @(posedge clk);
    @(negedge clk);
    wdata = wd;
    if (decoy) begin
      sel = 1'b1; addr = ERR_LO; trans = 2'd2; write = 1'b1; size = 3'd2;
    end else begin
      sel = 1'b0; trans = 2'd0; write = 1'b0;
    end
    lows = 0;
    low_err = 1'b0;
    while (!ready_out) begin
      lows++;
      if (resp) low_err = 1'b1;
      @(posedge clk);
      @(negedge clk);
    end
    fin_resp = resp;
    rd = rdata;
  endtask

  task automatic op_ok(input string req, input logic [31:0] a, input bit wr,
                       input logic [2:0] sz, input logic [31:0] wd,
                       input bit decoy, output logic [31:0] rd);
    int lows; bit le, fr;
    xfer(a, wr, sz, wd, 1'b1, 2'd2, decoy, lows, le, fr, rd);
    chk({req, " wait count"}, lows, 32'(wait_cfg));
    chk({req, " OKAY resp"}, {31'd0, fr | le}, 32'd0);
  endtask

  task automatic bus_idle();
    sel = 1'b0; trans = 2'd0; write = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ready in reset", {31'd0, ready_out}, 32'd1);
    chk("R1 resp in reset", {31'd0, resp}, 32'd0);
  endtask

  task automatic t_waits();
    logic [31:0] rd;
    for (int c = 0; c < 8; c += 3) begin
      wait_cfg = 3'(c == 6 ? 7 : c);
      op_ok("R2 write", 32'h30, 1'b1, 3'd2, 32'h5A00_0000 + 32'(c), 1'b0, rd);
      op_ok("R2 read", 32'h30, 1'b0, 3'd2, 32'h0, 1'b0, rd);
      chk("R4 read data", rd, 32'h5A00_0000 + 32'(c));
      bus_idle();
    end
  endtask

  task automatic t_idle_codes();
    logic [31:0] rd; int lows; bit le, fr;
    wait_cfg = 3'd2;
    op_ok("R3 setup", 32'h10, 1'b1, 3'd2, 32'h5555_5555, 1'b0, rd);
    xfer(32'h10, 1'b1, 3'd2, 32'hFFFF_FFFF, 1'b1, 2'd0, 1'b0, lows, le, fr, rd);
    chk("R3 idle zero wait", lows, 32'd0);
    chk("R3 idle OKAY", {31'd0, fr}, 32'd0);
    xfer(32'h10, 1'b1, 3'd2, 32'hEEEE_EEEE, 1'b1, 2'd1, 1'b0, lows, le, fr, rd);
    chk("R3 busy zero wait", lows, 32'd0);
    xfer(32'h10, 1'b1, 3'd2, 32'hDDDD_DDDD, 1'b0, 2'd2, 1'b0, lows, le, fr, rd);
    chk("R3 unselected zero wait", lows, 32'd0);
    chk("R3 unselected OKAY", {31'd0, fr}, 32'd0);
    op_ok("R3 readback", 32'h10, 1'b0, 3'd2, 32'h0, 1'b0, rd);
    chk("R3 storage untouched", rd, 32'h5555_5555);
    bus_idle();
  endtask

  task automatic t_lanes();
    logic [31:0] rd;
    wait_cfg = 3'd1;
    op_ok("R5 word", 32'h08, 1'b1, 3'd2, 32'h1122_3344, 1'b0, rd);
    op_ok("R5 byte1", 32'h09, 1'b1, 3'd0, 32'h0000_AA00, 1'b0, rd);
    op_ok("R5 read", 32'h08, 1'b0, 3'd2, 32'h0, 1'b0, rd);
    chk("R5 byte lane 1", rd, 32'h1122_AA44);
    op_ok("R5 half hi", 32'h0A, 1'b1, 3'd1, 32'hBEEF_0000, 1'b0, rd);
    op_ok("R5 byte3", 32'h0B, 1'b1, 3'd0, 32'h7700_0000, 1'b0, rd);
    op_ok("R5 read", 32'h08, 1'b0, 3'd2, 32'h0, 1'b0, rd);
    chk("R5 half then byte lanes", rd, 32'h77EF_AA44);
    bus_idle();
  endtask

  task automatic t_error();
    logic [31:0] rd; int lows; bit le, fr;
    wait_cfg = 3'd5;
    op_ok("R6 setup", 32'h00, 1'b1, 3'd2, 32'hA5A5_A5A5, 1'b0, rd);
    xfer(ERR_LO, 1'b1, 3'd2, 32'hDEAD_BEEF, 1'b1, 2'd2, 1'b0, lows, le, fr, rd);
    chk("R6 one low cycle", lows, 32'd1);
    chk("R6 first cycle ERROR", {31'd0, le}, 32'd1);
    chk("R6 second cycle ERROR", {31'd0, fr}, 32'd1);
    op_ok("R6 readback", 32'h00, 1'b0, 3'd2, 32'h0, 1'b0, rd);
    chk("R6 no storage write", rd, 32'hA5A5_A5A5);
    xfer(ERR_HI - 32'd3, 1'b0, 3'd2, 32'h0, 1'b1, 2'd3, 1'b0, lows, le, fr, rd);
    chk("R6 top of window low cycles", lows, 32'd1);
    chk("R6 top of window ERROR", {31'd0, fr & le}, 32'd1);
    op_ok("R6 below window", ERR_LO - 32'd4, 1'b1, 3'd2, 32'h0F0F_0F0F, 1'b0, rd);
    op_ok("R6 above window", ERR_HI + 32'd1, 1'b0, 3'd2, 32'h0, 1'b0, rd);
    chk("R6 above window data", rd, 32'hA5A5_A5A5);
    bus_idle();
  endtask

  task automatic t_gate();
    logic [31:0] rd;
    wait_cfg = 3'd4;
    op_ok("R7 stalled write", 32'h20, 1'b1, 3'd2, 32'hCAFE_0020, 1'b1, rd);
    op_ok("R7 read after decoy", 32'h20, 1'b0, 3'd2, 32'h0, 1'b0, rd);
    chk("R7 decoy ignored", rd, 32'hCAFE_0020);
    bus_idle();
  endtask

  task automatic t_pipe();
    logic [31:0] rd;
    wait_cfg = 3'd0;
    op_ok("R8 write", 32'h24, 1'b1, 3'd2, 32'h1234_5678, 1'b0, rd);
    op_ok("R8 read", 32'h24, 1'b0, 3'd2, 32'h0, 1'b0, rd);
    chk("R8 back-to-back data", rd, 32'h1234_5678);
    op_ok("R8 write", 32'h24, 1'b1, 3'd2, 32'h9ABC_DEF0, 1'b0, rd);
    op_ok("R8 read", 32'h24, 1'b0, 3'd2, 32'h0, 1'b0, rd);
    chk("R8 back-to-back data", rd, 32'h9ABC_DEF0);
    bus_idle();
  endtask

  initial begin
    rst_n = 1'b1;
    sel = 1'b0; addr = '0; trans = 2'd0; write = 1'b0; size = 3'd2;
    wdata = '0; wait_cfg = 3'd0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_waits();
    t_idle_codes();
    t_lanes();
    t_error();
    t_gate();
    t_pipe();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule